// File: doc/BRIEF.md
# Dirty-Plane Tracker with Delayed Self-Refresh Re-Arm

This block sits beside a panel self-refresh controller and decides, from frontbuffer activity, when self-refresh has to be abandoned and when it may be armed again. Software-side rendering events arrive as two strobes. An invalidate strobe says that some planes are being drawn into. A flush strobe says that drawing into some planes has finished. Each strobe carries a plane mask. A per-pipe relevance mask filters both masks, so planes on other pipes never matter. The filtered planes that are still dirty are kept in a busy mask.

An exit request pulse tells the refresh controller to leave self-refresh. When the busy mask drains to zero while refresh is off, the block starts a delay counted in ticks of an external millisecond strobe. When the delay runs out and nothing is dirty, the block waits a bounded time for the controller to report idle. If idle arrives in time, it emits a one-cycle re-arm pulse.

A build parameter picks one of two flavours. In the tracked flavour, flushes caused by a page flip do not force an exit, the delay is 100 ticks and the idle wait is 50 ticks. In the untracked flavour, every relevant flush forces an exit, the delay is 500 ticks and the idle wait is 1 tick.

Top module: `plane_dirty_tracker`

## Requirements
- R1: Before use, the invalidate and flush plane masks are ANDed with `relMask`. Plane bits outside `relMask` change neither `busyMask` nor `exitReq`.
- R2: An invalidate ORs its filtered bits into `busyMask`, visible the cycle after the strobe. It raises `exitReq` in that same following cycle when the filtered bits are non-zero.
- R3: A flush clears its filtered bits from `busyMask`, visible the cycle after the strobe.
- R4: A flush with non-zero filtered bits raises `exitReq` in the following cycle. With `FLIP_EXITS`=0 this happens only when `flushIsFlip` is 0. With `FLIP_EXITS`=1 it happens regardless of `flushIsFlip`.
- R5: A flush schedules a re-arm when it leaves `busyMask` zero and refresh is off, meaning `refreshActive` is 0 or the flush itself requests an exit. With a tick every cycle, `rearmReq` pulses DLY+1 cycles after the flush cycle if `refreshIdle` is high throughout. DLY is 100 when `FLIP_EXITS`=0 and 500 when it is 1.
- R6: When the delay expires while `busyMask` is non-zero, the re-arm is abandoned and no `rearmReq` is produced.
- R7: After the delay, `rearmReq` pulses in the cycle after `refreshIdle` is first seen high. If idle is not seen within TMO ticks, the re-arm is dropped. TMO is 50 when `FLIP_EXITS`=0 and 1 when it is 1.
- R8: While `featEn` is low, any pending re-arm is cancelled, both strobes are ignored (no `exitReq`), and `busyMask` reads zero. Re-enabling therefore starts with a clean mask.
- R9: A flush that meets the scheduling condition while a re-arm is pending restarts the delay from zero.
- R10: When invalidate and flush arrive in the same cycle, only the invalidate acts. The flush neither clears bits nor schedules a re-arm.
- R11: `exitReq` and `rearmReq` are registered single-cycle pulses. `rearmReq` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featEn | input | 1 | Feature enable level |
| relMask | input | NUM_PLANES | Planes belonging to the active pipe |
| invStrobe | input | 1 | Invalidate event |
| invMask | input | NUM_PLANES | Planes being dirtied |
| flushStrobe | input | 1 | Flush event |
| flushMask | input | NUM_PLANES | Planes flushed |
| flushIsFlip | input | 1 | Flush originated from a page flip |
| refreshActive | input | 1 | Self-refresh currently active |
| refreshIdle | input | 1 | Refresh controller reports idle |
| msTick | input | 1 | One-cycle strobe per timebase tick |
| exitReq | output | 1 | Pulse: leave self-refresh |
| rearmReq | output | 1 | Pulse: arm self-refresh again |
| busyMask | output | NUM_PLANES | Relevant planes still dirty |

## Verification
A corrupted busy mask shows on `busyMask` the cycle after the strobe that produced it. It can also show 101 or 501 cycles later, as a re-arm that should have been abandoned or one that is missing. A miscounted delay or idle-wait counter moves the `rearmReq` pulse off its expected cycle, or lets it appear after a drop. An exact-cycle event scoreboard exposes both faults at the first pulse. A stuck state in the re-arm sequencer shows as a pulse while the feature is disabled, or as a second pulse in consecutive cycles.

// File: rtl/prt_pkg.sv
package prt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DELAY    = 2'd1,
    ST_WAITIDLE = 2'd2
  } armState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic busyClr;
    logic busyOr;
    logic busyAnd;
    logic cntClr;
    logic cntInc;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic invHit;
    logic flushHit;
    logic flushLeavesClean;
    logic busyNextClean;
    logic delayDone;
    logic waitDone;
  } dpSts_t;

endpackage

// File: rtl/prt_datapath.sv
module prt_datapath
  import prt_pkg::*;
#(
  parameter int NUM_PLANES = 8,
  parameter int DLY_TICKS  = 100,
  parameter int TMO_TICKS  = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic [NUM_PLANES-1:0] relMask,
  input  logic [NUM_PLANES-1:0] invMask,
  input  logic [NUM_PLANES-1:0] flushMask,
  output logic [NUM_PLANES-1:0] busyMask,
  output dpSts_t                sts
);

  localparam int MAX_TICKS = (DLY_TICKS > TMO_TICKS) ? DLY_TICKS : TMO_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_TICKS - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_TICKS - 1);

  logic [NUM_PLANES-1:0] busyQ, busyD;
  logic [NUM_PLANES-1:0] invSel, flushSel;
  logic [CNT_W-1:0]      cntQ;

  assign invSel   = invMask & relMask;
  assign flushSel = flushMask & relMask;

  always_comb begin
    busyD = busyQ;
    if (ctl.busyClr)      busyD = '0;
    else if (ctl.busyOr)  busyD = busyQ | invSel;
    else if (ctl.busyAnd) busyD = busyQ & ~flushSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= busyD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cntQ <= '0;
    else if (ctl.cntClr) cntQ <= '0;
    else if (ctl.cntInc) cntQ <= cntQ + 1'b1;
  end

  assign busyMask             = busyQ;
  assign sts.invHit           = |invSel;
  assign sts.flushHit         = |flushSel;
  assign sts.flushLeavesClean = ~|(busyQ & ~flushSel);
  assign sts.busyNextClean    = ~|busyD;
  assign sts.delayDone        = (cntQ == DLY_LAST);
  assign sts.waitDone         = (cntQ == TMO_LAST);

endmodule

// File: rtl/prt_control.sv
module prt_control
  import prt_pkg::*;
#(
  parameter bit FLIP_EXITS = 1'b0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   featEn,
  input  logic   invStrobe,
  input  logic   flushStrobe,
  input  logic   flushIsFlip,
  input  logic   refreshActive,
  input  logic   refreshIdle,
  input  logic   msTick,
  input  dpSts_t sts,
  output dpCtl_t ctl,
  output logic   exitReq,
  output logic   rearmReq
);

  armState_e stateQ, stateD;
  logic      exitD, rearmD, schedule, flushExitOk;

  generate
    if (FLIP_EXITS) begin : gAnyFlush
      assign flushExitOk = 1'b1;
    end else begin : gSkipFlip
      assign flushExitOk = ~flushIsFlip;
    end
  endgenerate

  always_comb begin
    ctl      = '0;
    stateD   = stateQ;
    exitD    = 1'b0;
    rearmD   = 1'b0;
    schedule = 1'b0;
    if (!featEn) begin
      ctl.busyClr = 1'b1;
      stateD      = ST_IDLE;
    end else begin
      if (invStrobe) begin
        ctl.busyOr = 1'b1;
        exitD      = sts.invHit;
      end else if (flushStrobe) begin
        ctl.busyAnd = 1'b1;
        exitD       = sts.flushHit & flushExitOk;
        if ((!refreshActive || exitD) && sts.flushLeavesClean) begin
          schedule   = 1'b1;
          ctl.cntClr = 1'b1;
          stateD     = ST_DELAY;
        end
      end
      if (!schedule) begin
        unique case (stateQ)
          ST_DELAY: begin
            if (msTick) begin
              if (sts.delayDone) begin
                ctl.cntClr = 1'b1;
                stateD     = sts.busyNextClean ? ST_WAITIDLE : ST_IDLE;
              end else begin
                ctl.cntInc = 1'b1;
              end
            end
          end
          ST_WAITIDLE: begin
            if (refreshIdle) begin
              rearmD = sts.busyNextClean;
              stateD = ST_IDLE;
            end else if (msTick) begin
              if (sts.waitDone) stateD = ST_IDLE;
              else              ctl.cntInc = 1'b1;
            end
          end
          default: stateD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      exitReq  <= 1'b0;
      rearmReq <= 1'b0;
    end else begin
      stateQ   <= stateD;
      exitReq  <= exitD;
      rearmReq <= rearmD;
    end
  end

endmodule

// File: rtl/plane_dirty_tracker.sv
module plane_dirty_tracker
  import prt_pkg::*;
#(
  parameter int NUM_PLANES    = 8,
  parameter bit FLIP_EXITS    = 1'b0,
  parameter int DLY_TRACKED   = 100,
  parameter int DLY_UNTRACKED = 500,
  parameter int TMO_TRACKED   = 50,
  parameter int TMO_UNTRACKED = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  featEn,
  input  logic [NUM_PLANES-1:0] relMask,
  input  logic                  invStrobe,
  input  logic [NUM_PLANES-1:0] invMask,
  input  logic                  flushStrobe,
  input  logic [NUM_PLANES-1:0] flushMask,
  input  logic                  flushIsFlip,
  input  logic                  refreshActive,
  input  logic                  refreshIdle,
  input  logic                  msTick,
  output logic                  exitReq,
  output logic                  rearmReq,
  output logic [NUM_PLANES-1:0] busyMask
);

  localparam int DLY_TICKS = FLIP_EXITS ? DLY_UNTRACKED : DLY_TRACKED;
  localparam int TMO_TICKS = FLIP_EXITS ? TMO_UNTRACKED : TMO_TRACKED;

  dpCtl_t ctl;
  dpSts_t sts;

  prt_control #(.FLIP_EXITS(FLIP_EXITS)) uCtl (
    .clk(clk), .rstN(rstN), .featEn(featEn),
    .invStrobe(invStrobe), .flushStrobe(flushStrobe), .flushIsFlip(flushIsFlip),
    .refreshActive(refreshActive), .refreshIdle(refreshIdle), .msTick(msTick),
    .sts(sts), .ctl(ctl), .exitReq(exitReq), .rearmReq(rearmReq)
  );

  prt_datapath #(
    .NUM_PLANES(NUM_PLANES), .DLY_TICKS(DLY_TICKS), .TMO_TICKS(TMO_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .relMask(relMask),
    .invMask(invMask), .flushMask(flushMask), .busyMask(busyMask), .sts(sts)
  );

endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int NUM_PLANES = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  featEn,
  input logic [NUM_PLANES-1:0] relMask,
  input logic                  invStrobe,
  input logic [NUM_PLANES-1:0] invMask,
  input logic                  flushStrobe,
  input logic [NUM_PLANES-1:0] flushMask,
  input logic                  refreshIdle,
  input logic                  exitReq,
  input logic                  rearmReq,
  input logic [NUM_PLANES-1:0] busyMask
);

  assert_inv_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (featEn && invStrobe) |=>
      ((busyMask & $past(invMask & relMask)) == $past(invMask & relMask)));

  assert_flush_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (featEn && flushStrobe && !invStrobe) |=>
      ((busyMask & $past(flushMask & relMask)) == '0));

  assert_rearm_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    rearmReq |-> (busyMask == '0));

  assert_rearm_after_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    rearmReq |-> $past(refreshIdle));

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !featEn |=> (!exitReq && !rearmReq && busyMask == '0));

  assert_rearm_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    rearmReq |=> !rearmReq);

endmodule

bind plane_dirty_tracker prt_checker #(.NUM_PLANES(NUM_PLANES)) uChk (
  .clk(clk), .rstN(rstN), .featEn(featEn), .relMask(relMask),
  .invStrobe(invStrobe), .invMask(invMask), .flushStrobe(flushStrobe),
  .flushMask(flushMask), .refreshIdle(refreshIdle), .exitReq(exitReq),
  .rearmReq(rearmReq), .busyMask(busyMask)
);

// File: tb/sim_plane_dirty_tracker.sv
`timescale 1ns/1ps
module sim_plane_dirty_tracker;

  typedef struct {
    int     kind;   // 0 exitA, 1 rearmA, 2 exitB, 3 rearmB
    longint cyc;
    string  tag;
  } evt_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic featEnA = 1'b0, featEnB = 1'b0;
  logic [7:0] relMask = 8'h0F, invMask = '0, flushMask = '0;
  logic invStrobe = 1'b0, flushStrobe = 1'b0, flushIsFlip = 1'b0;
  logic refreshActive = 1'b0, refreshIdle = 1'b1, msTick = 1'b1;
  logic exitA, rearmA, exitB, rearmB;
  logic [7:0] busyA, busyB;

  evt_t   expQ[$];
  longint cyc = 0;
  int     applied = 0, miscompares = 0;
  bit     done = 1'b0;

  always #5 clk = ~clk;

  plane_dirty_tracker #(.NUM_PLANES(8), .FLIP_EXITS(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .featEn(featEnA), .relMask(relMask),
    .invStrobe(invStrobe), .invMask(invMask), .flushStrobe(flushStrobe),
    .flushMask(flushMask), .flushIsFlip(flushIsFlip), .refreshActive(refreshActive),
    .refreshIdle(refreshIdle), .msTick(msTick), .exitReq(exitA),
    .rearmReq(rearmA), .busyMask(busyA));

  plane_dirty_tracker #(.NUM_PLANES(8), .FLIP_EXITS(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .featEn(featEnB), .relMask(relMask),
    .invStrobe(invStrobe), .invMask(invMask), .flushStrobe(flushStrobe),
    .flushMask(flushMask), .flushIsFlip(flushIsFlip), .refreshActive(refreshActive),
    .refreshIdle(refreshIdle), .msTick(msTick), .exitReq(exitB),
    .rearmReq(rearmB), .busyMask(busyB));

  task automatic matchEvent(int k);
    applied++;
    if (expQ.size() > 0 && expQ[0].kind == k && expQ[0].cyc == cyc) begin
      void'(expQ.pop_front());
    end else begin
      miscompares++;
      if (expQ.size() > 0)
        $display("FAIL %s pulse actual kind=%0d at %0d expected kind=%0d at %0d",
                 expQ[0].tag, k, cyc, expQ[0].kind, expQ[0].cyc);
      else
        $display("FAIL R11 pulse actual kind=%0d at %0d expected none", k, cyc);
    end
  endtask

  // monitor: compares pulses against the expected queue
  always @(negedge clk) begin : monBlk
    logic [3:0] seen;
    seen = {rearmB, exitB, rearmA, exitA};
    if (rstN) begin
      for (int k = 0; k < 4; k++)
        if (seen[k]) matchEvent(k);
    end
    cyc++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitUntil(longint t);
    while (cyc < t) step(1);
  endtask

  task automatic expectEvt(int k, longint t, string tag);
    evt_t e;
    e.kind = k; e.cyc = t; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drain(string tag);
    while (expQ.size() > 0) begin
      applied++;
      miscompares++;
      $display("FAIL %s missing pulse actual none expected kind=%0d at %0d (%s)",
               tag, expQ[0].kind, expQ[0].cyc, expQ[0].tag);
      void'(expQ.pop_front());
    end
  endtask

  task automatic checkBusy(logic [7:0] act, logic [7:0] exp, string tag);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s busyMask actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic inv(logic [7:0] m);
    invStrobe = 1'b1; invMask = m;
    step(1);
    invStrobe = 1'b0; invMask = '0;
  endtask

  task automatic fl(logic [7:0] m, logic flip);
    flushStrobe = 1'b1; flushMask = m; flushIsFlip = flip;
    step(1);
    flushStrobe = 1'b0; flushMask = '0; flushIsFlip = 1'b0;
  endtask

  task automatic bounceA();
    featEnA = 1'b0; step(1); featEnA = 1'b1; step(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    longint c;
    step(3);
    rstN = 1'b1;
    step(1);
    // reset state
    checkBusy(busyA, 8'h00, "R8 reset");
    checkBusy(busyB, 8'h00, "R8 reset");
    featEnA = 1'b1;
    step(2);

    // R1: planes outside relMask ignored
    inv(8'hF0);
    checkBusy(busyA, 8'h00, "R1");
    step(5); drain("R1");

    // R2: invalidate accumulates and exits
    c = cyc; expectEvt(0, c, "R2"); inv(8'h03);
    checkBusy(busyA, 8'h03, "R2");
    c = cyc; expectEvt(0, c, "R2"); inv(8'h34);
    checkBusy(busyA, 8'h07, "R2");

    // R3/R4 tracked flavour
    refreshActive = 1'b1;
    fl(8'h01, 1'b1);
    checkBusy(busyA, 8'h06, "R3");
    c = cyc; expectEvt(0, c, "R4"); fl(8'h02, 1'b0);
    checkBusy(busyA, 8'h04, "R3");
    fl(8'h04, 1'b1);   // clean, active, no exit: no schedule
    checkBusy(busyA, 8'h00, "R3");
    step(150); drain("R5");

    // R5: inactive refresh schedules
    refreshActive = 1'b0;
    c = cyc; expectEvt(1, c + 101, "R5"); fl(8'h00, 1'b1);
    waitUntil(c + 110); drain("R5");
    // R5: flush's own exit counts as refresh off
    refreshActive = 1'b1;
    c = cyc; expectEvt(0, c, "R5"); expectEvt(1, c + 101, "R5"); fl(8'h01, 1'b0);
    waitUntil(c + 110); drain("R5");

    // R6: dirty at expiry abandons
    refreshActive = 1'b0;
    c = cyc; fl(8'h00, 1'b1);
    waitUntil(c + 10); expectEvt(0, c + 10, "R6"); inv(8'h02);
    waitUntil(c + 130); drain("R6");
    checkBusy(busyA, 8'h02, "R6");
    bounceA();

    // R7: idle timeout drops re-arm
    refreshIdle = 1'b0;
    c = cyc; fl(8'h00, 1'b1);
    waitUntil(c + 160); refreshIdle = 1'b1;
    step(20); drain("R7");
    // R7: late but in-window idle fires
    refreshIdle = 1'b0;
    c = cyc; fl(8'h00, 1'b1);
    waitUntil(c + 140); refreshIdle = 1'b1; expectEvt(1, c + 140, "R7");
    step(10); drain("R7");

    // R9: second flush restarts delay
    c = cyc; fl(8'h00, 1'b1);
    waitUntil(c + 50); expectEvt(1, c + 151, "R9"); fl(8'h00, 1'b1);
    waitUntil(c + 170); drain("R9");

    // R8: disable cancels and ignores strobes
    c = cyc; fl(8'h00, 1'b1);
    waitUntil(c + 20); featEnA = 1'b0;
    step(2); inv(8'h01);
    checkBusy(busyA, 8'h00, "R8");
    step(5); featEnA = 1'b1;
    waitUntil(c + 200); drain("R8");
    c = cyc; expectEvt(0, c, "R8"); inv(8'h03);
    checkBusy(busyA, 8'h03, "R8");
    bounceA();
    checkBusy(busyA, 8'h00, "R8 enable clears");

    // R10: invalidate wins over same-cycle flush
    c = cyc; expectEvt(0, c, "R10");
    invStrobe = 1'b1; invMask = 8'h01;
    flushStrobe = 1'b1; flushMask = 8'h01; flushIsFlip = 1'b0;
    step(1);
    invStrobe = 1'b0; invMask = '0; flushStrobe = 1'b0; flushMask = '0;
    checkBusy(busyA, 8'h01, "R10");
    step(150); drain("R10");
    bounceA();

    // R4/R5 untracked flavour
    featEnA = 1'b0; featEnB = 1'b1; refreshActive = 1'b1; refreshIdle = 1'b1;
    step(2);
    c = cyc; expectEvt(2, c, "R2"); inv(8'h01);
    checkBusy(busyB, 8'h01, "R2");
    c = cyc; expectEvt(2, c, "R4"); expectEvt(3, c + 501, "R5"); fl(8'h01, 1'b1);
    checkBusy(busyB, 8'h00, "R3");
    waitUntil(c + 510); drain("R5");

    // R7 untracked: one tick window
    refreshActive = 1'b0; refreshIdle = 1'b0;
    c = cyc; fl(8'h00, 1'b1);
    waitUntil(c + 502); refreshIdle = 1'b1;
    step(20); drain("R7");
    checkBusy(busyB, 8'h00, "R7");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule